// File: doc/BRIEF.md
# Prescaled Timer Counter with Compare Reset

This block is a 16-bit up-counter driven from the bus clock through a power-of-two prescaler. A control register selects the division ratio, enables an overflow interrupt and enables a modulus mode. In modulus mode the counter returns to zero one bus clock after it reaches the value in a compare register. The counter therefore repeats with a programmable period instead of running over the full 16-bit range.

An overflow flag is set when the counter wraps naturally from its top value to zero. The flag stays set until software clears it. A level interrupt request is driven while the flag is set and the interrupt is enabled. All state is reached through a small word-addressed register port. Writes take effect at the clock edge, and read data is combinational from the address.

Register map: address 0 is control, address 1 is the flag register, address 2 is the compare value, and address 3 is the counter, which is read-only.

Top module: `modtmr_top`

## Requirements
- R1: Control register (address 0) holds the overflow interrupt enable in bit 7, the compare-reset enable in bit 3 and the division select in bits 2:0. Bits 6:4 and 15:8 read as zero. Its reset value is 0.
- R2: With division select S, the counter advances by one every 2^S bus clocks (S = 0 gives 1 clock, S = 7 gives 128 clocks).
- R3: With compare reset disabled, the counter wraps from 0xFFFF to 0x0000, and that wrap sets the overflow flag, which reads at bit 7 of address 1.
- R4: Writing a 1 to bit 7 of address 1 clears the overflow flag. Writing a 0 there leaves the flag unchanged.
- R5: irq_o is high exactly while the overflow flag is set and the interrupt enable is 1. It is low whenever the enable is 0.
- R6: With compare reset enabled and a nonzero compare value C, the counter holds C for exactly one bus clock and then reads 0 on the next clock. One period then lasts C × 2^S + 1 bus clocks.
- R7: With compare reset enabled and a compare value of 0, a counter at 0 stays at 0 regardless of prescaler ticks.
- R8: With compare reset enabled and a compare value of 0xFFFF, the return from 0xFFFF to 0x0000 does not set the overflow flag.
- R9: A write that changes the division select restarts the prescaler, so the next advance comes a full 2^S clocks after the write edge.
- R10: The compare register (address 2) is read/write and resets to 0. The counter value reads at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The count rate is measured over a 256-clock window for all eight division codes. This shows whether each code picks its own divisor. Modulus mode is tried with two compare/divisor pairs, each measured between successive returns to zero. This separates the intended period from an off-by-one hold or a late reset. The compare values 0 and 0xFFFF are run against a natural wrap in free-run mode. Together they show whether the flag comes from a wrap or from a compare reset. A switch of division code part way through a prescaler period shows whether the prescaler restarts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int SEL_W  = 3;
    localparam int PRE_W  = (1 << SEL_W) - 1;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;

    localparam int IE_BIT   = 7;
    localparam int CLR_BIT  = 3;
    localparam int FLAG_BIT = 7;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

    typedef struct packed {
        logic             ovf_ie;
        logic             clr_en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = ~({PRE_W{1'b1}} << sel);
        tick = (st_q.pre == mask);
        st_d = st_q;
        if (restart || tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_en,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_st_t st_d, st_q;

    always_comb begin
        match = clr_en && (st_q.cnt == cmp);
        wrap  = tick && !match && (st_q.cnt == CNT_MAX);
        st_d  = st_q;
        if (match) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_flag,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag,
    output logic              sel_chg,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp;
        logic             flag;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        sel_chg = 1'b0;
        if (we) begin
            case (addr)
                A_CTRL: begin
                    st_d.ctrl.ovf_ie = wdata[IE_BIT];
                    st_d.ctrl.clr_en = wdata[CLR_BIT];
                    st_d.ctrl.sel    = wdata[SEL_W-1:0];
                    sel_chg          = (wdata[SEL_W-1:0] != st_q.ctrl.sel);
                end
                A_FLAG: begin
                    if (wdata[FLAG_BIT]) st_d.flag = 1'b0;
                end
                A_CMP:   st_d.cmp = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (set_flag) st_d.flag = 1'b1;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[IE_BIT]      = st_q.ctrl.ovf_ie;
                rdata[CLR_BIT]     = st_q.ctrl.clr_en;
                rdata[SEL_W-1:0]   = st_q.ctrl.sel;
            end
            A_FLAG:  rdata[FLAG_BIT] = st_q.flag;
            A_CMP:   rdata = DATA_W'(st_q.cmp);
            default: rdata = DATA_W'(cnt);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign cmp  = st_q.cmp;
    assign flag = st_q.flag;
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    ctrl_t            ctrl_s;
    logic [CNT_W-1:0] cmp_s;
    logic [CNT_W-1:0] cnt_s;
    logic             flag_s;
    logic             sel_chg_s;
    logic             tick_s;
    logic             match_s;
    logic             wrap_s;

    tmr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .set_flag (wrap_s),
        .cnt      (cnt_s),
        .ctrl     (ctrl_s),
        .cmp      (cmp_s),
        .flag     (flag_s),
        .sel_chg  (sel_chg_s),
        .rdata    (reg_rdata)
    );

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (ctrl_s.sel),
        .restart (sel_chg_s | match_s),
        .tick    (tick_s)
    );

    tmr_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_s),
        .clr_en (ctrl_s.clr_en),
        .cmp    (cmp_s),
        .cnt    (cnt_s),
        .match  (match_s),
        .wrap   (wrap_s)
    );

    assign irq_o = flag_s & ctrl_s.ovf_ie;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             ie,
    input logic             clr_en,
    input logic             flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(cnt) == TOP && cnt == '0)); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq_o); // R5

    AST_CLEAR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && cnt == cmp) |=> (cnt == '0)); // R6

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && cmp == '0 && cnt == '0) |=> (cnt == '0)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && cmp == TOP && cnt == TOP) |=> !$rose(flag)); // R8
endmodule

bind modtmr_top tmr_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .ie     (ctrl_s.ovf_ie),
    .clr_en (ctrl_s.clr_en),
    .flag   (flag_s),
    .cnt    (cnt_s),
    .cmp    (cmp_s)
);

// File: tb/sim_modtmr_top.sv
module sim_modtmr_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    modtmr_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Bring the counter to 0 held with compare 0, compare reset on, divide by 128.
    task automatic home();
        logic [15:0] c;
        int t;
        wr(2'd0, 16'h0007);
        rd(2'd3, c);
        wr(2'd2, c + 16'd2);
        wr(2'd0, 16'h000F);
        t = 0;
        do begin
            @(negedge clk);
            rd(2'd3, c);
            t++;
        end while (c != 16'h0 && t < 1000);
        wr(2'd2, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); check("R1 ctrl reset", v, 16'h0);
        rd(2'd2, v); check("R10 cmp reset", v, 16'h0);
        rd(2'd1, v); check("R3 flag reset", v, 16'h0);
        check("R5 irq reset", irq_o, 1'b0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R1 reserved bits read zero", v, 16'h008F);
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h1234);
        rd(2'd2, v); check("R10 cmp readback", v, 16'h1234);
    endtask

    task automatic t_divisors();
        logic [15:0] c0, c1;
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 16'(s));
            rd(2'd3, c0);
            repeat (256) @(negedge clk);
            rd(2'd3, c1);
            check($sformatf("R2 advance count sel=%0d", s), c1 - c0, 16'(256 >> s));
        end
    endtask

    task automatic t_restart();
        logic [15:0] c0, c1;
        wr(2'd0, 16'h0007);
        repeat (50) @(negedge clk);
        wr(2'd0, 16'h0006);
        rd(2'd3, c0);
        repeat (63) @(negedge clk);
        rd(2'd3, c1); check("R9 no advance before full period", c1, c0);
        @(negedge clk);
        rd(2'd3, c1); check("R9 advance after full period", c1, c0 + 16'd1);
    endtask

    task automatic t_zero();
        logic [15:0] c;
        bit bad = 1'b0;
        home();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rd(2'd3, c);
            if (c != 16'h0) bad = 1'b1;
        end
        check("R7 counter held at zero", bad, 1'b0);
    endtask

    task automatic t_period(input logic [15:0] cv, input logic [15:0] ctl, input int exp_len);
        logic [15:0] c, prev;
        int t, len, at_top;
        home();
        wr(2'd2, cv);
        wr(2'd0, ctl);
        rd(2'd3, prev);
        t = 0;
        do begin
            @(negedge clk); rd(2'd3, c);
            t++;
            if (c == 16'h0 && prev == cv) break;
            prev = c;
        end while (t < 5000);
        len = 0; at_top = 0; prev = c;
        do begin
            @(negedge clk); rd(2'd3, c);
            len++;
            if (c == cv) at_top++;
            if (c == 16'h0 && prev == cv) break;
            prev = c;
        end while (len < 5000);
        check($sformatf("R6 period cmp=%0d", cv), len, exp_len);
        check($sformatf("R6 clocks at compare value cmp=%0d", cv), at_top, 1);
    endtask

    task automatic t_wrap();
        logic [15:0] c, v;
        int t;
        home();
        wr(2'd0, 16'h0080);
        wr(2'd1, 16'h0080);
        rd(2'd1, v); check("R4 flag cleared before wrap", v, 16'h0);
        t = 0;
        do begin
            @(negedge clk); rd(2'd3, c); t++;
        end while (c != 16'hFFFF && t < 70000);
        rd(2'd1, v); check("R3 flag clear at top", v, 16'h0);
        @(negedge clk);
        rd(2'd3, c); check("R3 wrap to zero", c, 16'h0);
        rd(2'd1, v); check("R3 flag set by wrap", v, 16'h0080);
        check("R5 irq with flag and enable", irq_o, 1'b1);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); check("R4 writing zero keeps flag", v, 16'h0080);
        wr(2'd0, 16'h0000);
        check("R5 irq inhibited when disabled", irq_o, 1'b0);
        wr(2'd0, 16'h0080);
        check("R5 irq returns when enabled", irq_o, 1'b1);
        wr(2'd1, 16'h0080);
        rd(2'd1, v); check("R4 write one clears flag", v, 16'h0);
        check("R5 irq drops with flag", irq_o, 1'b0);
    endtask

    task automatic t_top_cmp();
        logic [15:0] c, v;
        int t;
        home();
        wr(2'd1, 16'h0080);
        wr(2'd2, 16'hFFFF);
        wr(2'd0, 16'h0008);
        t = 0;
        do begin
            @(negedge clk); rd(2'd3, c); t++;
        end while (c != 16'hFFFF && t < 70000);
        @(negedge clk);
        rd(2'd3, c); check("R8 compare reset to zero", c, 16'h0);
        rd(2'd1, v); check("R8 no flag on compare reset", v, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_divisors();
        t_restart();
        t_zero();
        t_period(16'd5, 16'h000A, 21);
        t_period(16'd3, 16'h0008, 4);
        t_wrap();
        t_top_cmp();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule